// File: doc/BRIEF.md
# Two-Event Classification Detector

This block follows the input-voltage band of a powered device while power sourcing equipment negotiates with it. Four comparator flags arrive from the same clock domain: the input is above the reset level, above the mark level, inside the classification window, and above the turn-on level. The block resynchronises the flags and accepts a band only once it has held steady for a set number of clocks. From the accepted band it drives the enable for the classification load and the enable for the mark load.

The block watches for a second-generation probe. That probe is a classification event, then a mark event, then a second classification event, then a second mark event, with power applied after it. When the block sees this probe, it latches a Type 2 flag. The flag survives undervoltage dropouts. Only a fall below the much lower reset level clears it. The Type 2 indication output is driven only while the device sits in the power band and the isolation switch reports fully on.

Top module: `t2_probe_tracker`

## Requirements
- R1: After reset, and while every comparator flag is low, the classification enable, mark enable, Type 2 flag and Type 2 indication are all 0.
- R2: The classification enable is 1 exactly while the accepted band is the classification window: reset flag 1, mark flag 1, window flag 1, turn-on flag 0.
- R3: The mark enable is 1 while the accepted band is below the mark level and above the reset level (reset flag 1, mark flag 0), but only once a classification event has been accepted since the last power entry or reset. Without that event the band counts as detection, and both loads stay off.
- R4: The Type 2 flag becomes 1 on entry to the power band (turn-on flag 1) when the accepted bands before it, ignoring the band between the mark level and the window, were classification, mark, classification, mark.
- R5: A single classification event, or a classification event and one mark event, followed by power entry, leaves the Type 2 flag at 0.
- R6: Once set, the Type 2 flag stays 1 through any band above the reset level. It clears when the reset band (reset flag 0) is accepted.
- R7: The Type 2 indication equals the Type 2 flag ANDed with the power band being accepted and with the switch-on input.
- R8: After a two-stage synchroniser, a new band is accepted only after STABLE_CLKS consecutive identical samples. A shorter excursion has no effect on any output.
- R9: The turn-on flag takes priority over the window flag, so the classification enable is 0 in the power band.
- R10: Entry to the power band restarts the probe sequence. Events seen before a power entry do not count towards a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_rst | input | 1 | Input above reset level |
| cmp_mark | input | 1 | Input above mark level (hysteresis is in the comparator) |
| cmp_cls | input | 1 | Input inside classification window |
| cmp_on | input | 1 | Input above turn-on level |
| sw_full | input | 1 | Isolation switch fully on |
| cls_load_en | output | 1 | Classification load enable |
| mark_load_en | output | 1 | Mark load enable |
| t2_flag | output | 1 | Latched Type 2 probe flag |
| t2_ind | output | 1 | Type 2 indication, power band only |

## Verification
Directed sequences separate a full two-event probe from the truncated probes (class then power; class, mark, then power), and from a probe split by a power entry, which shows whether the sequence restarts. A dropout and recovery sequence shows whether the flag survives the turn-off level but yields to the reset level. A short excursion into the window and an excursion of exactly the filter length show where the stability boundary lies. Random band walks with a random switch-on input are compared against a bench model of the band sequence.

// File: rtl/t2_probe_tracker.sv
module t2_probe_tracker #(
  parameter int STABLE_CLKS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_rst,
  input  logic cmp_mark,
  input  logic cmp_cls,
  input  logic cmp_on,
  input  logic sw_full,
  output logic cls_load_en,
  output logic mark_load_en,
  output logic t2_flag,
  output logic t2_ind
);
  localparam int CW = $clog2(STABLE_CLKS + 1);

  typedef enum logic [2:0] {B_RST, B_MARK, B_IDLE, B_CLS, B_PWR} band_t;
  typedef enum logic [2:0] {Q_NONE, Q_C1, Q_M1, Q_C2, Q_M2} seq_t;

  logic [3:0] sync_q [SYNC_STAGES];
  logic       s_rst, s_mark, s_cls, s_on;
  band_t      raw, cand, acc;
  seq_t       seq, seq_nx;
  logic       flag_nx;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {cmp_on, cmp_cls, cmp_mark, cmp_rst};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {s_on, s_cls, s_mark, s_rst} = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (!s_rst)       raw = B_RST;
    else if (s_on)    raw = B_PWR;
    else if (s_cls)   raw = B_CLS;
    else if (!s_mark) raw = B_MARK;
    else              raw = B_IDLE;
  end

  always_comb begin
    seq_nx  = seq;
    flag_nx = t2_flag;
    case (raw)
      B_RST: begin seq_nx = Q_NONE; flag_nx = 1'b0; end
      B_PWR: begin seq_nx = Q_NONE; if (seq == Q_M2) flag_nx = 1'b1; end
      B_CLS: begin
        if (seq == Q_NONE)      seq_nx = Q_C1;
        else if (seq == Q_M1)   seq_nx = Q_C2;
      end
      B_MARK: begin
        if (seq == Q_C1)        seq_nx = Q_M1;
        else if (seq == Q_C2)   seq_nx = Q_M2;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand    <= B_RST;
      acc     <= B_RST;
      cnt     <= '0;
      seq     <= Q_NONE;
      t2_flag <= 1'b0;
    end else if (raw == acc) begin
      cand <= acc;
      cnt  <= '0;
    end else if (raw != cand) begin
      cand <= raw;
      cnt  <= CW'(1);
    end else if (cnt == CW'(STABLE_CLKS - 1)) begin
      acc     <= raw;
      cnt     <= '0;
      seq     <= seq_nx;
      t2_flag <= flag_nx;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign cls_load_en  = (acc == B_CLS);
  assign mark_load_en = (acc == B_MARK) && (seq == Q_M1 || seq == Q_M2);
  assign t2_ind       = t2_flag && (acc == B_PWR) && sw_full;
endmodule

// File: rtl/t2_probe_tracker_chk.sv
module t2_probe_tracker_chk #(
  parameter int STABLE_CLKS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cmp_cls,
  input logic sw_full,
  input logic cls_load_en,
  input logic mark_load_en,
  input logic t2_flag,
  input logic t2_ind
);
  localparam int CW = $clog2(STABLE_CLKS + 1);
  logic [CW-1:0] run, prev_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      prev_run <= '0;
    end else if (cmp_cls) begin
      if (run != CW'(STABLE_CLKS)) run <= run + CW'(1);
    end else begin
      if (run != '0) prev_run <= run;
      run <= '0;
    end
  end

  p_loads_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cls_load_en && mark_load_en));
  p_cls_off_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cls_load_en |-> !t2_ind);
  p_ind_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    t2_ind |-> (t2_flag && sw_full));
  p_set_in_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t2_flag) |-> (!cls_load_en && !mark_load_en));
  p_clr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(t2_flag) |-> (!t2_ind && !cls_load_en && !mark_load_en));
  p_cls_filtered_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cls_load_en) |-> (run == CW'(STABLE_CLKS) || prev_run == CW'(STABLE_CLKS)));
endmodule

bind t2_probe_tracker t2_probe_tracker_chk #(.STABLE_CLKS(STABLE_CLKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmp_cls(cmp_cls), .sw_full(sw_full),
  .cls_load_en(cls_load_en), .mark_load_en(mark_load_en),
  .t2_flag(t2_flag), .t2_ind(t2_ind)
);

// File: tb/t2_probe_tracker_tb_top.sv
module t2_probe_tracker_tb_top;
  localparam int S = 4;
  localparam int B_RST = 0, B_MARK = 1, B_IDLE = 2, B_CLS = 3, B_PWR = 4;
  localparam int Q_NONE = 0, Q_C1 = 1, Q_M1 = 2, Q_C2 = 3, Q_M2 = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_rst = 0, cmp_mark = 0, cmp_cls = 0, cmp_on = 0, sw_full = 0;
  logic cls_load_en, mark_load_en, t2_flag, t2_ind;
  int n_cmp = 0, n_bad = 0;
  int m_band = B_RST, m_seq = Q_NONE;
  logic m_flag = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  t2_probe_tracker #(.STABLE_CLKS(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_rst(cmp_rst), .cmp_mark(cmp_mark),
    .cmp_cls(cmp_cls), .cmp_on(cmp_on), .sw_full(sw_full),
    .cls_load_en(cls_load_en), .mark_load_en(mark_load_en),
    .t2_flag(t2_flag), .t2_ind(t2_ind));

  task automatic chk(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
    end
  endtask

  task automatic set_flags(int b);
    cmp_rst  = (b != B_RST);
    cmp_mark = (b != B_RST) && (b != B_MARK);
    cmp_cls  = (b == B_CLS);
    cmp_on   = (b == B_PWR);
  endtask

  function automatic int seq_next(int q, int b);
    if (b == B_RST || b == B_PWR) return Q_NONE;
    if (b == B_CLS) return (q == Q_NONE) ? Q_C1 : (q == Q_M1) ? Q_C2 : q;
    if (b == B_MARK) return (q == Q_C1) ? Q_M1 : (q == Q_C2) ? Q_M2 : q;
    return q;
  endfunction

  function automatic logic exp_mark();
    return (m_band == B_MARK) && (m_seq == Q_M1 || m_seq == Q_M2);
  endfunction

  task automatic go(int b);
    @(negedge clk);
    set_flags(b);
    if (b != m_band) begin
      if (b == B_RST) m_flag = 1'b0;
      else if (b == B_PWR && m_seq == Q_M2) m_flag = 1'b1;
      m_seq  = seq_next(m_seq, b);
      m_band = b;
    end
    repeat (S + 6) @(negedge clk);
  endtask

  task automatic check_all(string rc, string rm, string rf, string ri);
    chk(rc, "cls_load_en", cls_load_en, m_band == B_CLS);
    chk(rm, "mark_load_en", mark_load_en, exp_mark());
    chk(rf, "t2_flag", t2_flag, m_flag);
    chk(ri, "t2_ind", t2_ind, m_flag && m_band == B_PWR && sw_full);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "cls_load_en", cls_load_en, 1'b0);
    chk("R1", "mark_load_en", mark_load_en, 1'b0);
    chk("R1", "t2_flag", t2_flag, 1'b0);
    chk("R1", "t2_ind", t2_ind, 1'b0);
    rst_n = 1'b1;
    repeat (S + 6) @(negedge clk);
    check_all("R1", "R1", "R1", "R1");

    // detection only: no mark load
    go(B_IDLE); go(B_MARK);
    chk("R3", "mark_load_en detect", mark_load_en, 1'b0);
    go(B_CLS);
    chk("R2", "cls_load_en", cls_load_en, 1'b1);
    go(B_MARK);
    chk("R3", "mark_load_en after class", mark_load_en, 1'b1);
    go(B_CLS); go(B_MARK);
    sw_full = 1'b1;
    go(B_PWR);
    chk("R4", "t2_flag full probe", t2_flag, 1'b1);
    chk("R7", "t2_ind", t2_ind, 1'b1);
    sw_full = 1'b0; @(negedge clk);
    chk("R7", "t2_ind switch off", t2_ind, 1'b0);
    sw_full = 1'b1;
    go(B_IDLE);
    chk("R6", "t2_flag dropout", t2_flag, 1'b1);
    chk("R7", "t2_ind dropout", t2_ind, 1'b0);
    go(B_PWR);
    chk("R6", "t2_ind recovered", t2_ind, 1'b1);
    go(B_MARK);
    chk("R6", "t2_flag above reset", t2_flag, 1'b1);
    go(B_RST);
    chk("R6", "t2_flag reset", t2_flag, 1'b0);

    go(B_IDLE); go(B_CLS); go(B_IDLE); go(B_PWR);
    chk("R5", "t2_flag single class", t2_flag, 1'b0);
    go(B_RST); go(B_CLS); go(B_MARK); go(B_PWR);
    chk("R5", "t2_flag one mark", t2_flag, 1'b0);

    go(B_RST); go(B_CLS); go(B_MARK); go(B_CLS); go(B_PWR);
    go(B_IDLE); go(B_CLS); go(B_MARK); go(B_PWR);
    chk("R10", "t2_flag split probe", t2_flag, 1'b0);

    // turn-on overrides window flag
    @(negedge clk);
    cmp_cls = 1'b1;
    repeat (S + 6) @(negedge clk);
    chk("R9", "cls_load_en in power", cls_load_en, 1'b0);
    go(B_IDLE);

    // short excursion into window
    set_flags(B_CLS);
    seen = 0;
    repeat (S - 1) begin @(negedge clk); seen |= cls_load_en; end
    set_flags(B_IDLE);
    repeat (S + 8) begin @(negedge clk); seen |= cls_load_en; end
    chk("R8", "cls_load_en short glitch", seen, 1'b0);
    chk("R8", "mark_load_en short glitch", mark_load_en, 1'b0);
    set_flags(B_CLS);
    seen = 0;
    repeat (S) begin @(negedge clk); seen |= cls_load_en; end
    set_flags(B_IDLE);
    repeat (S + 8) begin @(negedge clk); seen |= cls_load_en; end
    chk("R8", "cls_load_en exact length", seen, 1'b1);
    m_seq = seq_next(m_seq, B_CLS);

    for (int k = 0; k < 400; k++) begin
      int b;
      b = (k % 37 == 0) ? B_RST : int'($urandom_range(1, 4));
      sw_full = 1'($urandom_range(0, 1));
      go(b);
      check_all("R2", "R3", "R4", "R7");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule